// File: doc/BRIEF.md
# EDO DRAM Device-Side Control Model

This block is a clock-synchronous model of the control logic inside a 16-bit extended-data-out DRAM. It samples the row strobe, two column strobes (one per byte lane), write enable, output enable and a shared address bus on each clock edge. From these it decides when the row and column addresses are captured, whether a write reaches the small storage array, and when each byte lane drives its outputs or floats. The bidirectional data bus appears as a 16-bit input vector, a 16-bit output vector and one output-enable bit per byte lane.

All strobes are active low and sampled on the rising clock edge. A "fall" is a sample of 0 that follows a sample of 1, and a "rise" is the reverse. Every output is registered, so the response to the inputs sampled at one edge is visible immediately after that edge. A row state machine (`RS_IDLE`, `RS_OPEN`, `RS_REFRESH`) tracks the row cycle. `RS_IDLE` goes to `RS_OPEN` when the row strobe falls while the combined column strobe was inactive. `RS_IDLE` goes to `RS_REFRESH` when the row strobe falls while the combined column strobe was already active. Both `RS_OPEN` and `RS_REFRESH` return to `RS_IDLE` when the row strobe is high.

Each byte lane runs its own state machine with the states `LN_IDLE`, `LN_READ`, `LN_HOLD`, `LN_EARLY`, `LN_LATE` and `LN_BLOCK`. The transitions are:
- `LN_IDLE`/`LN_HOLD` go to `LN_EARLY` (with a write) when the lane's strobe falls with write enable low, and to `LN_READ` when it falls with write enable high.
- `LN_READ` goes to `LN_HOLD` when the lane's strobe rises. When write enable falls instead, it goes to `LN_LATE` (with a write) if output enable is high, or to `LN_BLOCK` (no write) if output enable is low.
- `LN_HOLD` goes to `LN_IDLE` when write enable is low.
- `LN_EARLY`, `LN_LATE` and `LN_BLOCK` go to `LN_IDLE` when the lane's strobe rises.
- Every lane state goes to `LN_IDLE` when the row strobe is high or the row is not open.

Top module: `edo_dram_model`

## Requirements
- R1: The combined column strobe is active while either lane strobe is low. The column address (`addr[COL_W-1:0]`) is captured only when this combined strobe goes from inactive to active. A lane whose strobe falls while the other lane's strobe is already low uses the column captured earlier, not the current address.
- R2: Each lane strobe governs only its own byte: bit 0 of `dq_oe` and `dq_out[7:0]` belong to `cas_lo_n`, and bit 1 and `dq_out[15:8]` belong to `cas_hi_n`. A write through one lane leaves the other byte of the stored word unchanged.
- R3: Write data is taken from `dq_in` at the later of two falls. In an early write it is taken at the lane strobe's fall. In a late write it is taken at the write-enable fall. A following read returns the written data one edge after the lane strobe falls.
- R4: In an early write (write enable low when the lane strobe falls), that lane's output enable stays 0 even while output enable is low.
- R5: If write enable falls after the lane strobe while output enable is low, nothing is stored, and the lane drives the data already stored at the addressed location.
- R6: After a read, the lane keeps driving the same data when its strobe rises, for as long as the row strobe and output enable stay low and write enable stays high.
- R7: While a lane is in a read cycle, raising output enable floats the lane at the next edge, and lowering it again restores the valid data.
- R8: If a column strobe is low at the sample before the row strobe falls, the row cycle is a refresh. No lane drives, and no write happens even if a lane strobe falls with write enable low.
- R9: Both lanes float at the edge that samples the row strobe high. A lane holding read data after its strobe rose floats at the edge that samples write enable low.
- R10: After reset, `dq_oe` is 0 and `dq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_lo_n | input | 1 | Lower-byte column strobe, active low |
| cas_hi_n | input | 1 | Upper-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 16 | Data presented for writes |
| dq_out | output | 16 | Data driven by the model |
| dq_oe | output | 2 | Per-lane drive enable (bit 0 lower byte) |

## Verification
A wrong row state shows at the ports as a refresh that drives data, or as an access whose read returns stale contents. A wrong lane state shows as a lane that drives during an early write, or one that floats during a hold. Both appear on `dq_oe` at the first edge after the triggering sample. A wrongly captured column or a write that should have been blocked stays hidden inside the array until a later read. That read exposes it one edge after its lane strobe falls, so the bench reads back every location after each write scenario.

// File: rtl/edo_pkg.sv
package edo_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_OPEN,
        RS_REFRESH
    } row_state_t;

    typedef enum logic [2:0] {
        LN_IDLE,
        LN_READ,
        LN_HOLD,
        LN_EARLY,
        LN_LATE,
        LN_BLOCK
    } lane_state_t;
endpackage

// File: rtl/edo_strobe_sync.sv
module edo_strobe_sync #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic             we_n,
    output logic             ras_fall,
    output logic [LANES-1:0] cas_fall,
    output logic [LANES-1:0] cas_rise,
    output logic             we_fall,
    output logic             cas_int_q,
    output logic             cas_int_fall
);
    logic             ras_q;
    logic [LANES-1:0] cas_q;
    logic             we_q;
    logic             cas_int_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= '1;
            we_q  <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            we_q  <= we_n;
        end
    end

    // combined strobe: active on first lane fall, inactive after last lane rise
    assign cas_int_n    = &cas_n;
    assign cas_int_q    = &cas_q;
    assign cas_int_fall = cas_int_q & ~cas_int_n;

    assign ras_fall = ras_q & ~ras_n;
    assign we_fall  = we_q & ~we_n;

    for (genvar i = 0; i < LANES; i++) begin : g_edge
        assign cas_fall[i] = cas_q[i] & ~cas_n[i];
        assign cas_rise[i] = ~cas_q[i] & cas_n[i];
    end
endmodule

// File: rtl/edo_row_ctrl.sv
module edo_row_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              ras_fall,
    input  logic              cas_int_q,
    input  logic              cas_int_fall,
    input  logic [ADDR_W-1:0] addr,
    output row_state_t        row_st,
    output logic [ROW_W-1:0]  row_q,
    output logic [COL_W-1:0]  col_eff
);
    row_state_t       row_nxt;
    logic [COL_W-1:0] col_q;

    always_comb begin
        row_nxt = row_st;
        unique case (row_st)
            RS_IDLE: begin
                if (ras_fall) row_nxt = cas_int_q ? RS_OPEN : RS_REFRESH;
            end
            RS_OPEN: begin
                if (ras_n) row_nxt = RS_IDLE;
            end
            RS_REFRESH: begin
                if (ras_n) row_nxt = RS_IDLE;
            end
            default: row_nxt = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_st <= RS_IDLE;
        else        row_st <= row_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else begin
            if (row_st == RS_IDLE && ras_fall) row_q <= addr[ROW_W-1:0];
            if (cas_int_fall)                   col_q <= addr[COL_W-1:0];
        end
    end

    assign col_eff = cas_int_fall ? addr[COL_W-1:0] : col_q;

    // R1: column stays put while the combined strobe was already active
    assert_col_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_int_q |=> $stable(col_q));
endmodule

// File: rtl/edo_word_array.sv
module edo_word_array #(
    parameter int IDX_W  = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [IDX_W-1:0]        idx,
    input  logic [LANES-1:0]        wr_be,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [LANES*LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (wr_be[i]) mem[idx][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
        end
    end

    assign rd_data = mem[idx];
endmodule

// File: rtl/edo_lane.sv
module edo_lane
    import edo_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_open,
    input  logic              ras_n,
    input  logic              cas_fall,
    input  logic              cas_rise,
    input  logic              we_n,
    input  logic              we_fall,
    input  logic              oe_n,
    input  logic [LANE_W-1:0] rd_byte,
    output logic              wr_en,
    output logic [LANE_W-1:0] dout,
    output logic              drive
);
    lane_state_t st_q;
    lane_state_t st_nxt;

    always_comb begin
        st_nxt = st_q;
        wr_en  = 1'b0;
        if (!row_open || ras_n) begin
            st_nxt = LN_IDLE;
        end else begin
            unique case (st_q)
                LN_IDLE, LN_HOLD: begin
                    if (cas_fall) begin
                        if (!we_n) begin
                            st_nxt = LN_EARLY;
                            wr_en  = 1'b1;
                        end else begin
                            st_nxt = LN_READ;
                        end
                    end else if (st_q == LN_HOLD && !we_n) begin
                        st_nxt = LN_IDLE;
                    end
                end
                LN_READ: begin
                    if (cas_rise) begin
                        st_nxt = LN_HOLD;
                    end else if (we_fall) begin
                        if (oe_n) begin
                            st_nxt = LN_LATE;
                            wr_en  = 1'b1;
                        end else begin
                            st_nxt = LN_BLOCK;
                        end
                    end
                end
                LN_EARLY, LN_LATE, LN_BLOCK: begin
                    if (cas_rise) st_nxt = LN_IDLE;
                end
                default: st_nxt = LN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LN_IDLE;
        else        st_q <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive <= 1'b0;
            dout  <= '0;
        end else begin
            drive <= !oe_n && (st_nxt == LN_READ || st_nxt == LN_HOLD || st_nxt == LN_BLOCK);
            if (st_nxt == LN_READ || st_nxt == LN_BLOCK) dout <= rd_byte;
        end
    end

    // R4: an early write never drives the lane
    assert_early_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LN_EARLY) |-> !drive);

    // R5: a blocked late write stores nothing for the rest of the cycle
    assert_block_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LN_BLOCK) |-> !wr_en);
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model
    import edo_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int IDX_W  = ROW_W + COL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ras_n,
    input  logic                  cas_lo_n,
    input  logic                  cas_hi_n,
    input  logic                  we_n,
    input  logic                  oe_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     dq_in,
    output logic [DATA_W-1:0]     dq_out,
    output logic [LANES-1:0]      dq_oe
);
    logic             ras_fall;
    logic [LANES-1:0] cas_fall;
    logic [LANES-1:0] cas_rise;
    logic             we_fall;
    logic             cas_int_q;
    logic             cas_int_fall;
    row_state_t       row_st;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_eff;
    logic [LANES-1:0] wr_be;
    logic [DATA_W-1:0] rd_data;

    edo_strobe_sync #(.LANES(LANES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .ras_n       (ras_n),
        .cas_n       ({cas_hi_n, cas_lo_n}),
        .we_n        (we_n),
        .ras_fall    (ras_fall),
        .cas_fall    (cas_fall),
        .cas_rise    (cas_rise),
        .we_fall     (we_fall),
        .cas_int_q   (cas_int_q),
        .cas_int_fall(cas_int_fall)
    );

    edo_row_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_row (
        .clk         (clk),
        .rst_n       (rst_n),
        .ras_n       (ras_n),
        .ras_fall    (ras_fall),
        .cas_int_q   (cas_int_q),
        .cas_int_fall(cas_int_fall),
        .addr        (addr),
        .row_st      (row_st),
        .row_q       (row_q),
        .col_eff     (col_eff)
    );

    edo_word_array #(.IDX_W(IDX_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk    (clk),
        .idx    ({row_q, col_eff}),
        .wr_be  (wr_be),
        .wr_data(dq_in),
        .rd_data(rd_data)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        edo_lane #(.LANE_W(LANE_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .row_open(row_st == RS_OPEN),
            .ras_n   (ras_n),
            .cas_fall(cas_fall[i]),
            .cas_rise(cas_rise[i]),
            .we_n    (we_n),
            .we_fall (we_fall),
            .oe_n    (oe_n),
            .rd_byte (rd_data[i*LANE_W +: LANE_W]),
            .wr_en   (wr_be[i]),
            .dout    (dq_out[i*LANE_W +: LANE_W]),
            .drive   (dq_oe[i])
        );
    end

    // R9: row strobe high floats both lanes at the next edge
    assert_ras_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ras_n |=> (dq_oe == '0));

    // R7: output enable high floats both lanes at the next edge
    assert_oe_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (dq_oe == '0));

    // R8: a refresh row cycle never drives
    assert_refresh_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (row_st == RS_REFRESH) |=> (dq_oe == '0));
endmodule

// File: tb/tb_edo_dram_model.sv
module tb_edo_dram_model;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, cas_lo_n = 1'b1, cas_hi_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out;
    logic [1:0]    dq_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    edo_dram_model dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // present inputs for one clock; return at the next falling edge
    task automatic cyc(logic r, logic l, logic h, logic w, logic o, logic [AW-1:0] a, logic [15:0] d);
        ras_n = r; cas_lo_n = l; cas_hi_n = h; we_n = w; oe_n = o; addr = a; dq_in = d;
        @(negedge clk);
    endtask

    task automatic early_write(logic [AW-1:0] row, logic [AW-1:0] col, logic lo, logic hi, logic [15:0] d);
        cyc(0, 1, 1, 1, 1, row, 16'h0);
        cyc(0, !lo, !hi, 0, 0, col, d);
        check("R4 early write floats", {14'b0, dq_oe}, 16'h0);
        cyc(0, 1, 1, 1, 1, col, 16'h0);
        cyc(1, 1, 1, 1, 1, '0, 16'h0);
    endtask

    task automatic read_word(logic [AW-1:0] row, logic [AW-1:0] col, logic [15:0] exp, string req);
        cyc(0, 1, 1, 1, 1, row, 16'h0);
        cyc(0, 0, 0, 1, 0, col, 16'h0);
        check({req, " read enables"}, {14'b0, dq_oe}, 16'h3);
        check({req, " read data"}, dq_out, exp);
        cyc(0, 1, 1, 1, 0, col, 16'h0);
        check("R6 hold enables", {14'b0, dq_oe}, 16'h3);
        check("R6 hold data", dq_out, exp);
        cyc(1, 1, 1, 1, 1, '0, 16'h0);
        check("R9 row high floats", {14'b0, dq_oe}, 16'h0);
    endtask

    task automatic t_reset;
        check("R10 reset oe", {14'b0, dq_oe}, 16'h0);
        check("R10 reset data", dq_out, 16'h0);
    endtask

    task automatic t_early;
        early_write(4'd2, 4'd5, 1, 1, 16'hA55A);
        early_write(4'd2, 4'd6, 1, 1, 16'h0F0F);
        read_word(4'd2, 4'd5, 16'hA55A, "R3 early");
    endtask

    task automatic t_late;
        cyc(0, 1, 1, 1, 1, 4'd2, 16'h0);
        cyc(0, 0, 0, 1, 1, 4'd6, 16'h0);
        cyc(0, 0, 0, 0, 1, 4'd9, 16'h1234);
        check("R3 late write floats", {14'b0, dq_oe}, 16'h0);
        cyc(0, 1, 1, 1, 1, 4'd9, 16'h0);
        cyc(1, 1, 1, 1, 1, '0, 16'h0);
        read_word(4'd2, 4'd6, 16'h1234, "R3 late");
    endtask

    task automatic t_blocked;
        cyc(0, 1, 1, 1, 1, 4'd2, 16'h0);
        cyc(0, 0, 0, 1, 0, 4'd5, 16'h0);
        cyc(0, 0, 0, 0, 0, 4'd5, 16'hFFFF);
        check("R5 blocked drives", {14'b0, dq_oe}, 16'h3);
        check("R5 blocked data", dq_out, 16'hA55A);
        cyc(0, 1, 1, 1, 1, 4'd5, 16'h0);
        cyc(1, 1, 1, 1, 1, '0, 16'h0);
        read_word(4'd2, 4'd5, 16'hA55A, "R5 unchanged");
    endtask

    task automatic t_byte;
        early_write(4'd2, 4'd5, 1, 0, 16'hEE77);
        read_word(4'd2, 4'd5, 16'hA577, "R2 lower byte");
        cyc(0, 1, 1, 1, 1, 4'd2, 16'h0);
        cyc(0, 1, 0, 1, 0, 4'd5, 16'h0);
        check("R2 upper lane only", {14'b0, dq_oe}, 16'h2);
        check("R2 upper data", {8'h0, dq_out[15:8]}, 16'h00A5);
        cyc(1, 1, 1, 1, 1, '0, 16'h0);
    endtask

    task automatic t_stagger;
        cyc(0, 1, 1, 1, 1, 4'd2, 16'h0);
        cyc(0, 0, 1, 1, 0, 4'd5, 16'h0);
        cyc(0, 0, 0, 1, 0, 4'd6, 16'h0);
        check("R1 second lane keeps column", dq_out, 16'hA577);
        check("R1 both lanes drive", {14'b0, dq_oe}, 16'h3);
        cyc(0, 1, 1, 1, 0, 4'd6, 16'h0);
        cyc(0, 0, 1, 1, 0, 4'd6, 16'h0);
        check("R1 new column latched", dq_out, 16'hA534);
        cyc(1, 1, 1, 1, 1, '0, 16'h0);
    endtask

    task automatic t_oe_toggle;
        cyc(0, 1, 1, 1, 1, 4'd2, 16'h0);
        cyc(0, 0, 0, 1, 0, 4'd6, 16'h0);
        cyc(0, 0, 0, 1, 1, 4'd6, 16'h0);
        check("R7 oe high floats", {14'b0, dq_oe}, 16'h0);
        cyc(0, 0, 0, 1, 0, 4'd6, 16'h0);
        check("R7 oe low drives", {14'b0, dq_oe}, 16'h3);
        check("R7 oe low data", dq_out, 16'h1234);
        cyc(1, 1, 1, 1, 1, '0, 16'h0);
    endtask

    task automatic t_we_hold;
        cyc(0, 1, 1, 1, 1, 4'd2, 16'h0);
        cyc(0, 0, 0, 1, 0, 4'd5, 16'h0);
        cyc(0, 1, 1, 1, 0, 4'd5, 16'h0);
        cyc(0, 1, 1, 1, 0, 4'd5, 16'h0);
        check("R6 hold persists", dq_out, 16'hA577);
        cyc(0, 1, 1, 0, 0, 4'd5, 16'h0);
        check("R9 we low floats hold", {14'b0, dq_oe}, 16'h0);
        cyc(1, 1, 1, 1, 1, '0, 16'h0);
    endtask

    task automatic t_refresh;
        cyc(1, 0, 0, 1, 0, 4'd2, 16'h0);
        cyc(0, 0, 0, 1, 0, 4'd2, 16'h0);
        check("R8 refresh no drive", {14'b0, dq_oe}, 16'h0);
        cyc(0, 1, 1, 1, 0, 4'd5, 16'h0);
        cyc(0, 0, 0, 0, 0, 4'd5, 16'hDEAD);
        check("R8 refresh strobe no drive", {14'b0, dq_oe}, 16'h0);
        cyc(0, 1, 1, 1, 1, 4'd5, 16'h0);
        cyc(1, 1, 1, 1, 1, '0, 16'h0);
        read_word(4'd2, 4'd5, 16'hA577, "R8 no write");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_early();
        t_late();
        t_blocked();
        t_byte();
        t_stagger();
        t_oe_toggle();
        t_we_hold();
        t_refresh();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule